// File: doc/BRIEF.md
# Microcontroller Byte-Port Slave with Command/Data Decode

This block is the slave side of a small parallel bus that a microcontroller uses to reach a device. The device takes up two byte locations. One of them is the command location and the other is the data location. The master drives active-low chip select, read strobe and write strobe, plus an 8-bit bus that runs in both directions. The block turns each complete bus access into a single-clock strobe for the logic behind it. That logic can be a register file or an endpoint buffer. A write to the command location raises `cmd_wr`, a write to the data location raises `data_wr`, and a read of the data location raises `data_rd`. Write strobes come with the captured byte on `wr_byte`.

The location select comes from one of two places. With the address-latch-enable input tied low, the select is the dedicated address pin. When the master pulses ALE, the block captures an address byte from the data bus. It closes that latch when ALE falls and takes the select from bit 0 of the captured byte. The address pin is then ignored. All bus inputs pass through a two-flop synchroniser into the block's clock domain. The bus is presented as a split input, output and output enable, so the pad tri-state stays outside this block.

Top module: `mcu_bus_port`

## Requirements
- R1: While reset is high and right after it, `bus_d_oe`, `cmd_wr`, `data_wr` and `data_rd` are all 0, and the select is taken from the address pin.
- R2: With ALE held low, a write with the address pin at 1 gives exactly one `cmd_wr` pulse. A write with the pin at 0 gives exactly one `data_wr` pulse. In both cases `wr_byte` holds the byte that was on the bus while the write strobe was low.
- R3: With ALE held low, a read with the address pin at 0 gives exactly one `data_rd` pulse. A read with the pin at 1 (command location) gives no strobe.
- R4: `bus_d_oe` is 1 only while chip select and read strobe have both been low, delayed by a fixed latency of three clocks. While it is 1, `bus_d_o` carries `rd_byte`. It returns to 0 within three clocks after the read strobe is released.
- R5: A read or write made while chip select is high produces no strobe and leaves `bus_d_oe` at 0.
- R6: After any ALE pulse, the select is bit 0 of the address byte latched when ALE fell (1 selects command, 0 selects data), and the address pin has no effect. This mode stays in force until reset.
- R7: Bus values after the fall of ALE do not change the latched select. This includes a data byte whose bit 0 differs from the address byte.
- R8: Every strobe is one clock wide. It is issued after the bus strobe is released, not while the strobe is held. It appears four clocks after the release is first sampled.

Bus and strobe encodings: all of `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are active low. On the address pin and on the latched address bit, 1 means command and 0 means data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select from the master, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_a0 | input | 1 | Dedicated location select (1 command, 0 data) |
| bus_ale | input | 1 | Address latch enable; tie low for separate buses |
| bus_d_i | input | 8 | Bus value seen at the pads |
| bus_d_o | output | 8 | Byte driven onto the bus during reads |
| bus_d_oe | output | 1 | Pad output enable for the bus |
| rd_byte | input | 8 | Read value from the logic behind the port |
| cmd_wr | output | 1 | One-clock command write strobe |
| data_wr | output | 1 | One-clock data write strobe |
| data_rd | output | 1 | One-clock data read strobe |
| wr_byte | output | 8 | Byte of the most recent write |

## Verification
The bench changes the bus value one clock after a write strobe is released. A design that sampled the byte from the raw pins instead of from the synchronised copy would then report that later value on `wr_byte`. In multiplexed cycles, the address pin and bit 0 of the data byte are set opposite to the latched address bit. A design that kept the latch open past the fall of ALE, or that still looked at the pin, would pick the wrong location. Command reads and accesses with chip select high are each expected to give no strobe. A design that decoded reads without the select, or ignored chip select, would show up in the scoreboard as an unexpected pulse. The scoreboard also counts pulses that are wider than one clock or that fire while a strobe is still held.

// File: rtl/mcu_bus_pkg.sv
package mcu_bus_pkg;
  // location select encoding on the pin and in the latched address byte
  typedef enum logic {
    LOC_DATA = 1'b0,
    LOC_CMD  = 1'b1
  } loc_sel_e;

  // index of each strobe tracker
  localparam int unsigned TRK_RD = 0;
  localparam int unsigned TRK_WR = 1;
  localparam int unsigned TRK_N  = 2;
endpackage

// File: rtl/mcu_bus_sync.sv
module mcu_bus_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RESET_VAL;
    else     chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= RESET_VAL;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mcu_bus_addr.sv
module mcu_bus_addr #(
  parameter int unsigned DW      = 8,
  parameter int unsigned SEL_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_s,
  input  logic          a0_s,
  input  logic [DW-1:0] d_s,
  output logic          sel
);
  logic          mux_mode_q;
  logic [DW-1:0] addr_q;

  // latch is transparent while ALE is high; its last value is kept when ALE falls
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_mode_q <= 1'b0;
      addr_q     <= '0;
    end else if (ale_s) begin
      mux_mode_q <= 1'b1;
      addr_q     <= d_s;
    end
  end

  assign sel = mux_mode_q ? addr_q[SEL_BIT] : a0_s;
endmodule

// File: rtl/mcu_bus_strobe.sv
module mcu_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic stb_n_s,
  input  logic sel,
  output logic rel,
  output logic rel_sel
);
  logic prev_q, armed_q, sel_q;
  logic active;

  assign active = ~cs_n_s & ~stb_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
      rel     <= 1'b0;
      rel_sel <= 1'b0;
    end else begin
      prev_q <= stb_n_s;
      rel    <= 1'b0;
      if (active) begin
        armed_q <= 1'b1;
        sel_q   <= sel;
      end else if (stb_n_s && !prev_q) begin
        rel     <= armed_q;
        rel_sel <= sel_q;
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcu_bus_port.sv
module mcu_bus_port #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_BIT     = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_a0,
  input  logic          bus_ale,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe,
  input  logic [DW-1:0] rd_byte,
  output logic          cmd_wr,
  output logic          data_wr,
  output logic          data_rd,
  output logic [DW-1:0] wr_byte
);
  import mcu_bus_pkg::*;

  localparam int unsigned SW = DW + 5;
  localparam logic [SW-1:0] IDLE = {{DW{1'b0}}, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic [SW-1:0] raw, synced;
  logic [DW-1:0] d_s;
  logic          a0_s, ale_s, cs_n_s, rd_n_s, wr_n_s;
  logic          sel;
  logic [TRK_N-1:0] stb_n_s, rel, rel_sel;

  assign raw = {bus_d_i, bus_a0, bus_ale, bus_cs_n, bus_rd_n, bus_wr_n};

  mcu_bus_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE)) i_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(synced)
  );

  assign {d_s, a0_s, ale_s, cs_n_s, rd_n_s, wr_n_s} = synced;

  mcu_bus_addr #(.DW(DW), .SEL_BIT(SEL_BIT)) i_addr (
    .clk(clk), .rst(rst), .ale_s(ale_s), .a0_s(a0_s), .d_s(d_s), .sel(sel)
  );

  assign stb_n_s[TRK_RD] = rd_n_s;
  assign stb_n_s[TRK_WR] = wr_n_s;

  for (genvar t = 0; t < TRK_N; t++) begin : g_trk
    mcu_bus_strobe i_trk (
      .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .stb_n_s(stb_n_s[t]),
      .sel(sel), .rel(rel[t]), .rel_sel(rel_sel[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wr   <= 1'b0;
      data_wr  <= 1'b0;
      data_rd  <= 1'b0;
      wr_byte  <= '0;
      bus_d_o  <= '0;
      bus_d_oe <= 1'b0;
    end else begin
      cmd_wr   <= rel[TRK_WR] & (rel_sel[TRK_WR] == LOC_CMD);
      data_wr  <= rel[TRK_WR] & (rel_sel[TRK_WR] == LOC_DATA);
      data_rd  <= rel[TRK_RD] & (rel_sel[TRK_RD] == LOC_DATA);
      bus_d_oe <= ~cs_n_s & ~rd_n_s;
      if (~cs_n_s & ~wr_n_s) wr_byte <= d_s;
      if (~cs_n_s & ~rd_n_s) bus_d_o <= rd_byte;
    end
  end
endmodule

// File: rtl/mcu_bus_port_chk.sv
module mcu_bus_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_d_oe,
  input logic          cmd_wr,
  input logic          data_wr,
  input logic          data_rd,
  input logic [DW-1:0] wr_byte
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_QUIET: assert (!bus_d_oe && !cmd_wr && !data_wr && !data_rd) // R1
        else $error("outputs active after reset");
    end
  end

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> $past(!bus_cs_n && !bus_rd_n, 3)); // R4

  AST_RD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    data_rd |-> $past(bus_rd_n, 4)); // R8

  AST_WR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr || data_wr) |-> $past(bus_wr_n, 4)); // R8

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr || data_wr || data_rd) |=> !(cmd_wr || data_wr || data_rd)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_wr, data_wr, data_rd})); // R2

  AST_WR_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr || data_wr) |-> $stable(wr_byte)); // R2
endmodule

bind mcu_bus_port mcu_bus_port_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_d_oe(bus_d_oe), .cmd_wr(cmd_wr),
  .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte)
);

// File: tb/test_mcu_bus_port.sv
module test_mcu_bus_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic       bus_a0 = 1'b0, bus_ale = 1'b0;
  logic [7:0] bus_d_i = 8'h00, rd_byte = 8'h00;
  logic [7:0] bus_d_o, wr_byte;
  logic       bus_d_oe, cmd_wr, data_wr, data_rd;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         kind;   // 0 cmd_wr, 1 data_wr, 2 data_rd
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t sb[$];
  exp_t mon_e;
  int   mon_k;

  always #10 clk = ~clk;

  mcu_bus_port i_mcu_bus_port (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_a0(bus_a0), .bus_ale(bus_ale),
    .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe),
    .rd_byte(rd_byte), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .data_rd(data_rd), .wr_byte(wr_byte)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every strobe seen
  always @(negedge clk) begin
    if (!rst && (cmd_wr || data_wr || data_rd)) begin
      mon_k = cmd_wr ? 0 : (data_wr ? 1 : 2);
      if (sb.size() == 0) begin
        chk(1'b0, "R5", "unexpected strobe kind", mon_k, -1);
      end else begin
        mon_e = sb.pop_front();
        chk(mon_k == mon_e.kind, mon_e.req, "strobe kind", mon_k, mon_e.kind);
        if (mon_k != 2)
          chk(wr_byte == mon_e.val, mon_e.req, "written byte", wr_byte, mon_e.val);
      end
    end
  end

  task automatic write_cycle(bit a0pin, bit sel_exp, logic [7:0] b, bit cs_on, string req);
    exp_t e;
    if (cs_on) begin
      e.kind = sel_exp ? 0 : 1; e.val = b; e.req = req;
      sb.push_back(e);
    end
    @(negedge clk); bus_d_i = b; bus_a0 = a0pin; bus_cs_n = ~cs_on;
    @(negedge clk); bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(sb.size() == int'(cs_on), "R8", "strobe pending while write held", sb.size(), int'(cs_on));
    repeat (2) @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1; bus_d_i = ~b;  // bus changes right after release
    repeat (8) @(negedge clk);
    chk(sb.size() == 0, req, "write strobes outstanding", sb.size(), 0);
    chk(bus_d_oe == 1'b0, "R4", "oe during write", bus_d_oe, 0);
  endtask

  task automatic read_cycle(bit a0pin, bit sel_exp, logic [7:0] v, bit cs_on, string req);
    exp_t e;
    if (cs_on && !sel_exp) begin
      e.kind = 2; e.val = 8'h00; e.req = req;
      sb.push_back(e);
    end
    @(negedge clk); bus_d_i = 8'h00; bus_a0 = a0pin; bus_cs_n = ~cs_on; rd_byte = v;
    @(negedge clk); bus_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(bus_d_oe == cs_on, cs_on ? "R4" : "R5", "oe while read held", bus_d_oe, int'(cs_on));
    if (cs_on) chk(bus_d_o == v, "R4", "read byte on bus", bus_d_o, v);
    chk(sb.size() == int'(cs_on && !sel_exp), "R8", "strobe pending while read held",
        sb.size(), int'(cs_on && !sel_exp));
    bus_rd_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_d_oe == 1'b0, "R4", "oe after read release", bus_d_oe, 0);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, req, "read strobes outstanding", sb.size(), 0);
  endtask

  task automatic ale_phase(logic [7:0] addr);
    @(negedge clk); bus_d_i = addr; bus_ale = 1'b1;
    repeat (3) @(negedge clk);
    bus_ale = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(bus_d_oe == 1'b0 && !cmd_wr && !data_wr && !data_rd, "R1", "outputs in reset",
        {bus_d_oe, cmd_wr, data_wr, data_rd}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(bus_d_oe == 1'b0, "R1", "oe after reset", bus_d_oe, 0);
    chk({cmd_wr, data_wr, data_rd} == 3'b000, "R1", "strobes after reset",
        {cmd_wr, data_wr, data_rd}, 0);

    // separate bus mode, select from the pin
    write_cycle(1'b1, 1'b1, 8'h3C, 1'b1, "R2");
    write_cycle(1'b0, 1'b0, 8'hA5, 1'b1, "R2");
    write_cycle(1'b0, 1'b0, 8'h00, 1'b1, "R2");
    write_cycle(1'b1, 1'b1, 8'hFF, 1'b1, "R2");
    read_cycle(1'b0, 1'b0, 8'h5A, 1'b1, "R3");
    read_cycle(1'b1, 1'b1, 8'hC3, 1'b1, "R3");
    // chip select not asserted
    write_cycle(1'b1, 1'b1, 8'h77, 1'b0, "R5");
    read_cycle(1'b0, 1'b0, 8'h99, 1'b0, "R5");

    // multiplexed mode: pin and data bit 0 opposite to latched bit
    ale_phase(8'h01); write_cycle(1'b0, 1'b1, 8'h3E, 1'b1, "R6");
    ale_phase(8'h80); write_cycle(1'b1, 1'b0, 8'h81, 1'b1, "R7");
    ale_phase(8'h02); read_cycle(1'b1, 1'b0, 8'h6B, 1'b1, "R6");
    ale_phase(8'h03); read_cycle(1'b0, 1'b1, 8'h14, 1'b1, "R6");
    // no new ALE: latched select 1 still applies, pin ignored
    write_cycle(1'b0, 1'b1, 8'h42, 1'b1, "R6");

    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R8", "final scoreboard", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule